// File: doc/BRIEF.md
# Multicycle Unified-Memory Datapath

This block is the datapath of a 32-bit RISC processor that runs each instruction over several clock cycles. It has no sequencing of its own. An external controller drives one set of control strobes and selects every cycle. The datapath returns the current opcode and the ALU zero flag so that the controller can choose its next state.

Inside the block there is a program counter, an instruction register, a memory data register, a 32-entry register file and two operand latches. There is also an ALU with a result latch and its function decoder, an immediate sign extender, a word-offset shifter and a jump-target builder. Fetches and data accesses share one word-addressed memory, and an address select picks which of the two uses it in a given cycle. Every intermediate value goes into a register at each clock edge. A step in one cycle therefore only uses values that were stored at the end of the cycle before.

The memory contents are placed in the internal array before the block runs. Results can be observed through the program counter and the ALU result register.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, the instruction register and the ALU result register clear to zero, so `pc_o`, `opcode_o` and `alu_out_o` read zero.
- R2: With `ir_write`=1 the instruction register loads the memory word at the address in effect that cycle, and `opcode_o` shows its bits [31:26]. A fetch cycle uses `i_or_d`=0, `alu_src_a`=0, `alu_src_b`=01, `alu_op`=00, `pc_source`=00 and `pc_write`=1, and it advances `pc_o` by 4. With `ir_write`=0 the opcode holds.
- R3: The A latch loads the register named by instruction bits [25:21] on every cycle, and the B latch loads the register named by bits [20:16]. The first ALU input is the program counter when `alu_src_a`=0 and A when it is 1. The second ALU input is selected by `alu_src_b`: 00 gives B, 01 gives the constant 4, 10 gives the sign-extended bits [15:0], and 11 gives that value shifted left by 2. The ALU result register loads on every cycle.
- R4: `alu_op`=00 adds and 01 subtracts. `alu_op`=10 decodes instruction bits [5:0]: 100000 is add, 100010 is subtract, 100100 is bitwise AND, 100101 is bitwise OR, and 101010 is signed set-less-than, which gives 1 or 0.
- R5: With `i_or_d`=1 the memory is addressed by the ALU result register. The memory data register captures the word read, and `mem_write`=1 writes B to that word at the clock edge.
- R6: With `reg_write`=1 the register file writes at the clock edge. The target is register bits [15:11] when `reg_dst`=1 and bits [20:16] when it is 0. The data is the memory data register when `mem_to_reg`=1 and the ALU result register when it is 0. If A or B reads a register in the same cycle it is written, the latch captures the value from before the write.
- R7: With `pc_write_cond`=1, `pc_write`=0 and `pc_source`=01, the program counter takes the ALU result register only when the zero flag is set, and otherwise it holds. With both write strobes low it always holds.
- R8: `pc_source`=10 with `pc_write`=1 loads the program counter with its own bits [31:28], followed by instruction bits [25:0], followed by two zero bits.
- R9: Register 0 always reads as zero. A write that targets it has no effect.
- R10: `zero_o` is 1 exactly when the current combinational ALU result is zero.
- R11: The memory is word addressed through address bits [31:2] within its depth, and address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_write | input | 1 | Unconditional program counter write |
| pc_write_cond | input | 1 | Program counter write when the zero flag is set |
| i_or_d | input | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_write | input | 1 | Store B into memory |
| ir_write | input | 1 | Load instruction register |
| mem_to_reg | input | 1 | Register write data: 0 ALU result register, 1 memory data register |
| reg_dst | input | 1 | Register write target: 0 bits [20:16], 1 bits [15:11] |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | First ALU input: 0 program counter, 1 A |
| alu_src_b | input | 2 | Second ALU input select |
| alu_op | input | 2 | ALU operation class |
| pc_source | input | 2 | Next program counter: 00 ALU result, 01 ALU result register, 10 jump target |
| opcode_o | output | 6 | Instruction register bits [31:26] |
| zero_o | output | 1 | ALU result is zero |
| pc_o | output | 32 | Program counter |
| alu_out_o | output | 32 | ALU result register |

## Verification
Two functions can meet in one cycle: the register file write-back of an instruction and the A/B latch refresh from the same instruction's source fields. The bench provokes this with R-type instructions whose destination equals the first source. Right after the write-back edge it runs one more A+B cycle and requires the sum of the pre-write operands. Branch cycles also combine the subtraction with the conditional program-counter load. Here the bench judges `zero_o` just before the edge and `pc_o` after it, against operand pairs that are both equal and unequal.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JMP_W   = 26;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_SLT
  } alu_fn_e;

  localparam logic [FN_W-1:0] FUNCT_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FUNCT_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FUNCT_AND = 6'b100100;
  localparam logic [FN_W-1:0] FUNCT_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FUNCT_SLT = 6'b101010;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] PCSRC_ALU  = 2'b00;
  localparam logic [1:0] PCSRC_REG  = 2'b01;
  localparam logic [1:0] PCSRC_JUMP = 2'b10;
endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int RA_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [RA_W-1:0] raddr_a,
  input  logic [RA_W-1:0] raddr_b,
  output logic [W-1:0]    rdata_a,
  output logic [W-1:0]    rdata_b
);
  logic [W-1:0] rf_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rf_q[i] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)
          rf_q[i] <= '0;
        else if (we && waddr == RA_W'(i))
          rf_q[i] <= wdata;
      end
    end
  end

  assign rdata_a = rf_q[raddr_a];
  assign rdata_b = rf_q[raddr_b];
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]      alu_op,
  input  logic [FN_W-1:0] funct,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  output logic [W-1:0]    result,
  output logic            zero
);
  alu_fn_e fn;

  always_comb begin
    unique case (alu_op)
      2'b00: fn = FN_ADD;
      2'b01: fn = FN_SUB;
      2'b10: begin
        case (funct)
          FUNCT_SUB: fn = FN_SUB;
          FUNCT_AND: fn = FN_AND;
          FUNCT_OR:  fn = FN_OR;
          FUNCT_SLT: fn = FN_SLT;
          default:   fn = FN_ADD;
        endcase
      end
      default: fn = FN_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      FN_SUB:  result = opnd_a - opnd_b;
      FN_AND:  result = opnd_a & opnd_b;
      FN_OR:   result = opnd_a | opnd_b;
      FN_SLT:  result = W'($signed(opnd_a) < $signed(opnd_b));
      default: result = opnd_a + opnd_b;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/mcd_memory.sv
module mcd_memory #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] idx;
  logic          unused_addr_bits;

  assign idx              = addr[AW+1:2];
  assign unused_addr_bits = ^{addr[W-1:AW+2], addr[1:0]};

  always_ff @(posedge clk) begin
    if (we)
      mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int W      = 32,
  parameter int MEM_AW = 8,
  parameter int REGS   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_write,
  input  logic             pc_write_cond,
  input  logic             i_or_d,
  input  logic             mem_write,
  input  logic             ir_write,
  input  logic             mem_to_reg,
  input  logic             reg_dst,
  input  logic             reg_write,
  input  logic             alu_src_a,
  input  logic [1:0]       alu_src_b,
  input  logic [1:0]       alu_op,
  input  logic [1:0]       pc_source,
  output logic [OPC_W-1:0] opcode_o,
  output logic             zero_o,
  output logic [W-1:0]     pc_o,
  output logic [W-1:0]     alu_out_o
);
  localparam int RA_W = $clog2(REGS);

  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [W-1:0] mem_addr, mem_rdata;
  logic [W-1:0] rf_a, rf_b, rf_wdata;
  logic [RA_W-1:0] rf_waddr;
  logic [W-1:0] imm_ext, imm_shl, jump_tgt;
  logic [W-1:0] src_a, src_b, alu_y, pc_next;
  logic         alu_zero, pc_en;

  assign imm_ext  = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_shl  = {imm_ext[W-3:0], 2'b00};
  assign jump_tgt = {pc_q[W-1:JMP_W+2], ir_q[JMP_W-1:0], 2'b00};

  assign mem_addr = i_or_d ? alu_out_q : pc_q;

  mcd_memory #(.W(W), .AW(MEM_AW)) mem_i (
    .clk   (clk),
    .we    (mem_write),
    .addr  (mem_addr),
    .wdata (b_q),
    .rdata (mem_rdata)
  );

  assign rf_waddr = reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = mem_to_reg ? mdr_q : alu_out_q;

  mcd_regfile #(.W(W), .N(REGS)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_write),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (ir_q[25:21]),
    .raddr_b (ir_q[20:16]),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  assign src_a = alu_src_a ? a_q : pc_q;

  always_comb begin
    unique case (alu_src_b)
      SRCB_REG:   src_b = b_q;
      SRCB_FOUR:  src_b = W'(4);
      SRCB_IMM:   src_b = imm_ext;
      default:    src_b = imm_shl;
    endcase
  end

  mcd_alu #(.W(W)) alu_i (
    .alu_op (alu_op),
    .funct  (ir_q[FN_W-1:0]),
    .opnd_a (src_a),
    .opnd_b (src_b),
    .result (alu_y),
    .zero   (alu_zero)
  );

  always_comb begin
    unique case (pc_source)
      PCSRC_REG:  pc_next = alu_out_q;
      PCSRC_JUMP: pc_next = jump_tgt;
      default:    pc_next = alu_y;
    endcase
  end

  assign pc_en = pc_write | (pc_write_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_en)
        pc_q <= pc_next;
      if (ir_write)
        ir_q <= mem_rdata;
      mdr_q     <= mem_rdata;
      a_q       <= rf_a;
      b_q       <= rf_b;
      alu_out_q <= alu_y;
    end
  end

  assign opcode_o  = ir_q[INSTR_W-1:INSTR_W-OPC_W];
  assign zero_o    = alu_zero;
  assign pc_o      = pc_q;
  assign alu_out_o = alu_out_q;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         pc_write,
  input logic         pc_write_cond,
  input logic         i_or_d,
  input logic         mem_write,
  input logic         ir_write,
  input logic         mem_to_reg,
  input logic         reg_dst,
  input logic         reg_write,
  input logic         alu_src_a,
  input logic [1:0]   alu_src_b,
  input logic [1:0]   alu_op,
  input logic [1:0]   pc_source,
  input logic [5:0]   opcode_o,
  input logic         zero_o,
  input logic [W-1:0] pc_o,
  input logic [W-1:0] alu_out_o
);
  logic unused_ctl;
  assign unused_ctl = ^{i_or_d, mem_write, mem_to_reg, reg_dst, reg_write};

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_source == 2'b00 && !alu_src_a && alu_src_b == 2'b01 && alu_op == 2'b00)
    |=> pc_o == $past(pc_o) + W'(4)); // R2

  AST_OPCODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_write |=> $stable(opcode_o)); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && !pc_write_cond) |=> $stable(pc_o)); // R7

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (pc_write_cond && !pc_write && zero_o && pc_source == 2'b01)
    |=> pc_o == $past(alu_out_o)); // R7

  AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
    (pc_write_cond && !pc_write && !zero_o) |=> $stable(pc_o)); // R7

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_source == 2'b10)
    |=> (pc_o[1:0] == 2'b00 && pc_o[W-1:W-4] == $past(pc_o[W-1:W-4]))); // R8

  AST_ZERO_PC_INC: assert property (@(posedge clk) disable iff (rst)
    (!alu_src_a && alu_src_b == 2'b01 && alu_op == 2'b00 && pc_o != {{(W-2){1'b1}}, 2'b00})
    |-> !zero_o); // R10
endmodule

bind mc_datapath mcd_checker #(.W(W)) chk_i (.*);

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic pc_write, pc_write_cond, i_or_d, mem_write, ir_write;
  logic mem_to_reg, reg_dst, reg_write, alu_src_a;
  logic [1:0] alu_src_b, alu_op, pc_source;
  logic [5:0]  opcode_o;
  logic        zero_o;
  logic [31:0] pc_o, alu_out_o;

  mc_datapath dut_i (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [256];
  logic [31:0] m_pc;

  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010,
                         F_AND = 6'b100100, F_OR = 6'b100101, F_SLT = 6'b101010;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [5:0] fsel(int k);
    case (k)
      0: return F_ADD;
      1: return F_SUB;
      2: return F_AND;
      3: return F_OR;
      default: return F_SLT;
    endcase
  endfunction

  function automatic logic [31:0] model_alu(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    case (f)
      F_SUB: return a - b;
      F_AND: return a & b;
      F_OR:  return a | b;
      F_SLT: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] dval(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hFFFF_0000;
      default: return 32'h0000_0001;
    endcase
  endfunction

  task automatic idle();
    pc_write = 0; pc_write_cond = 0; i_or_d = 0; mem_write = 0; ir_write = 0;
    mem_to_reg = 0; reg_dst = 0; reg_write = 0; alu_src_a = 0;
    alu_src_b = 2'b00; alu_op = 2'b00; pc_source = 2'b00;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_word(int idx, logic [31:0] val);
    dut_i.mem_i.mem_q[idx] = val;
    m_mem[idx] = val;
  endtask

  task automatic fetch(logic [31:0] instr);
    put_word(int'(m_pc[9:2]), instr);
    idle(); ir_write = 1; pc_write = 1; alu_src_b = 2'b01;
    cyc();
    chk("R2 pc advance", pc_o, m_pc + 32'd4);
    chk("R2 opcode", {26'd0, opcode_o}, {26'd0, instr[31:26]});
    m_pc = m_pc + 32'd4;
  endtask

  task automatic decode(logic [31:0] instr);
    idle(); alu_src_b = 2'b11;
    cyc();
    chk("R3 shifted offset add", alu_out_o, m_pc + (sext(instr[15:0]) << 2));
  endtask

  task automatic exec_j(logic [25:0] t);
    logic [31:0] instr;
    instr = {6'd2, t};
    fetch(instr);
    decode(instr);
    idle(); pc_write = 1; pc_source = 2'b10;
    cyc();
    m_pc = {m_pc[31:28], t, 2'b00};
    chk("R8 jump target", pc_o, m_pc);
  endtask

  task automatic maybe_wrap();
    if (m_pc >= 32'd400) exec_j(26'd0);
  endtask

  task automatic exec_r(int rs, int rt, int rd, logic [5:0] f, string tag, bit probe);
    logic [31:0] instr, exp, old_a, old_b;
    maybe_wrap();
    instr = {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
    old_a = m_reg[rs];
    old_b = m_reg[rt];
    exp = model_alu(f, old_a, old_b);
    fetch(instr);
    decode(instr);
    idle(); alu_src_a = 1; alu_op = 2'b10;
    #1;
    chk("R10 zero flag", {31'd0, zero_o}, {31'd0, exp == 32'd0});
    cyc();
    chk(tag, alu_out_o, exp);
    idle(); reg_dst = 1; reg_write = 1;
    cyc();
    if (rd != 0) m_reg[rd] = exp;
    if (probe) begin
      idle(); alu_src_a = 1;
      cyc();
      chk("R6 same-cycle read sees old value", alu_out_o, old_a + old_b);
    end
  endtask

  task automatic exec_mem(bit store, int rs, int rt, logic [15:0] imm);
    logic [31:0] instr, addr;
    maybe_wrap();
    instr = {store ? 6'd43 : 6'd35, 5'(rs), 5'(rt), imm};
    addr = m_reg[rs] + sext(imm);
    fetch(instr);
    decode(instr);
    idle(); alu_src_a = 1; alu_src_b = 2'b10;
    cyc();
    chk("R5 effective address", alu_out_o, addr);
    idle(); i_or_d = 1; mem_write = store;
    cyc();
    if (store) begin
      m_mem[addr[9:2]] = m_reg[rt];
    end else begin
      idle(); mem_to_reg = 1; reg_write = 1;
      cyc();
      if (rt != 0) m_reg[rt] = m_mem[addr[9:2]];
    end
  endtask

  task automatic exec_beq(int rs, int rt, logic [15:0] imm);
    logic [31:0] instr, tgt;
    bit eq;
    maybe_wrap();
    instr = {6'd4, 5'(rs), 5'(rt), imm};
    eq = (m_reg[rs] == m_reg[rt]);
    fetch(instr);
    decode(instr);
    tgt = m_pc + (sext(imm) << 2);
    idle(); alu_src_a = 1; alu_op = 2'b01; pc_write_cond = 1; pc_source = 2'b01;
    #1;
    chk("R10 zero on compare", {31'd0, zero_o}, {31'd0, eq});
    cyc();
    if (eq) m_pc = tgt;
    chk("R7 conditional pc", pc_o, m_pc);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 256; i++) put_word(i, 32'd0);
    for (int k = 0; k < 8; k++) put_word(192 + k, dval(k));
    m_pc = 32'd0;
    rst = 1'b1;
    idle();
    @(negedge clk);
    cyc(); cyc();
    chk("R1 reset pc", pc_o, 32'd0);
    chk("R1 reset alu result", alu_out_o, 32'd0);
    chk("R1 reset opcode", {26'd0, opcode_o}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < 8; k++) begin
      exec_mem(1'b0, 0, k + 1, 16'(768 + 4 * k));
      exec_r(k + 1, 0, 20, F_ADD, "R5 load data readback", 1'b0);
    end

    for (int i = 1; i <= 8; i++)
      for (int j = 1; j <= 8; j++)
        for (int f = 0; f < 5; f++)
          exec_r(i, j, 9 + ((i + j + f) % 6), fsel(f), "R4 function result", 1'b0);

    for (int i = 1; i <= 8; i++)
      for (int j = 1; j <= 8; j++)
        exec_beq(i, j, 16'((i + j) % 4 - 1));

    for (int k = 0; k < 8; k++) begin
      exec_mem(1'b1, 0, 8 - k, 16'(800 + 4 * k + (k % 4)));
      exec_mem(1'b0, 0, 16, 16'(800 + 4 * k + ((k + 1) % 4)));
      exec_r(16, 0, 17, F_ADD, "R11 word addressed store/load", 1'b0);
    end

    exec_r(2, 0, 0, F_OR, "R9 write to r0 result", 1'b0);
    exec_r(0, 0, 18, F_OR, "R9 r0 reads zero after write", 1'b0);
    exec_mem(1'b0, 0, 0, 16'd772);
    exec_r(0, 0, 18, F_ADD, "R9 r0 zero after load", 1'b0);

    exec_j(26'd50);
    exec_j(26'd10);

    for (int k = 1; k <= 6; k++)
      exec_r(k, k + 1, k, F_ADD, "R6 writeback to rd", 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule